// File: doc/BRIEF.md
# SPI Master Shift Engine with Programmable Character Gap

This block is the serial core of an SPI master. A host hands it one transmit word at a time through a valid/ready handshake. The block clocks the word out on `spi_out` while it samples `spi_in` on the opposite clock edge. It returns each received character with a one-cycle valid strobe. A character is 8 or 16 bits and is always sent most significant bit first. Clock polarity and clock phase are static configuration inputs. The serial clock is the system clock divided by an even, programmable ratio.

After each character the engine can hold `spi_clk` at its idle level for a programmable pause. The pause is a 10-bit count of serial clock periods, and a scale bit can multiply it by 32. With a zero pause the engine reloads at the final edge of a character, so the clock runs without a break for as long as the host keeps a word waiting. If no word is waiting when a character or a pause ends, the clock stays idle and the engine waits for the next word.

The controller has three states. In IDLE the clock is at its idle level and a word is accepted at once. SHIFT runs the serial edges of one character. GAP holds the clock idle while the pause runs down. The transitions are:
- IDLE to SHIFT when a word is accepted.
- SHIFT to SHIFT at the last edge when the pause is zero and a word is waiting.
- SHIFT to GAP at the last edge when the pause is non-zero.
- SHIFT to IDLE at the last edge when the pause is zero and no word is waiting.
- GAP to SHIFT when the pause expires and a word is waiting.
- GAP to IDLE when the pause expires and no word is waiting.

Top module: `spi_gap_master`

## Requirements
- R1: While no transfer is in progress, `spi_clk` rests at `cfg_cpol`: low for 0, high for 1. It also rests at this level for the whole of every pause.
- R2: A character is 16 bits of `tx_data` when `cfg_wide`=1 and `tx_data[7:0]` when `cfg_wide`=0. It is sent MSB first and produces exactly twice its bit count of `spi_clk` edges.
- R3: With `cfg_cpha`=0, `spi_out` carries the MSB before the first edge. The input is sampled on each leading edge (the edge leaving the idle level), and `spi_out` moves on trailing edges.
- R4: With `cfg_cpha`=1, `spi_out` moves on each leading edge and the input is sampled on each trailing edge, so the first sample falls on the second edge.
- R5: Successive `spi_clk` edges within a character are `cfg_div`+1 system clocks apart. The first edge comes `cfg_div`+1 clocks after the word is accepted.
- R6: With `cfg_gap`=G non-zero, the final edge of one character and the first edge of the next are (`cfg_div`+1)·(1+2G) system clocks apart when `cfg_gap_x32`=0, and (`cfg_div`+1)·(1+64G) apart when it is 1.
- R7: With `cfg_gap`=0 and the next word waiting, the next character follows with no extra idle time: every edge spacing stays `cfg_div`+1.
- R8: If no word is waiting when a character or pause ends, the engine returns to IDLE and clocks no partial character. `busy` falls in the same cycle as the final edge when the pause is zero, and 2G·(`cfg_div`+1) clocks after it otherwise.
- R9: `rx_valid` pulses for one cycle after the last bit of a character is sampled. `rx_data` then holds the character, zero-extended in its upper 8 bits when `cfg_wide`=0.
- R10: A word is taken on a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is high in IDLE, at the final edge of a character when the pause is zero, and on the cycle a pause expires. It is low at all other times.
- R11: `busy` is low after reset. It is high from the cycle after a word is accepted until the engine is back in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 0: sample on leading edges, 1: sample on trailing edges |
| cfg_wide | input | 1 | 1: 16-bit characters, 0: 8-bit characters |
| cfg_div | input | DIV_W | Serial half-period minus one, in system clocks |
| cfg_gap | input | GAP_W | Pause after each character, in serial clock periods |
| cfg_gap_x32 | input | 1 | Multiplies the pause by 32 |
| tx_valid | input | 1 | Host has a word to send |
| tx_data | input | DATA_W | Word to send |
| tx_ready | output | 1 | Engine takes the word this cycle |
| rx_valid | output | 1 | One-cycle strobe for a received character |
| rx_data | output | DATA_W | Received character |
| busy | output | 1 | Transfer or pause in progress |
| spi_clk | output | 1 | Serial clock |
| spi_out | output | 1 | Serial data out |
| spi_in | input | 1 | Serial data in |

## Verification
The critical coincidence is the final serial edge of a character landing in the same cycle as the acceptance of the next word, with the input sample, the reload of the shift register and the `rx_valid` strobe all at that edge. The bench provokes it by holding `tx_valid` high with the next word while the pause is zero. It judges the result by the edge-to-edge spacing across the character boundary, which must equal the normal half-period, and by both characters arriving intact on `rx_data`. A second case runs a pause expiring with and without a waiting word. It measures from the final edge to the next edge, or to the fall of `busy`, in system clocks.

// File: rtl/spi_gap_pkg.sv
package spi_gap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } spi_state_e;

endpackage

// File: rtl/spi_gap_baud.sv
// Half-period strobe generator: one tick every (div+1) clocks while run is high.
module spi_gap_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/spi_gap_timer.sv
// Pause timer counted in half-period ticks; gap periods are doubled, optionally scaled.
module spi_gap_timer #(
    parameter int GAP_W    = 10,
    parameter int PRE_LOG2 = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GAP_W-1:0] gap,
    input  logic             x32,
    input  logic             tick,
    output logic             expire,
    output logic             zero
);

    localparam int CNT_W = GAP_W + PRE_LOG2 + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] plain_val;
    logic [CNT_W-1:0] scaled_val;

    assign plain_val  = {{PRE_LOG2{1'b0}}, gap, 1'b0};
    assign scaled_val = {gap, 1'b0, {PRE_LOG2{1'b0}}};
    assign zero       = (gap == '0);
    assign expire     = tick && (cnt == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= x32 ? scaled_val : plain_val;
        end else if (tick && (cnt != '0)) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

endmodule

// File: rtl/spi_gap_shifter.sv
// Transmit and receive shift registers, MSB first, 8/16-bit characters.
module spi_gap_shifter #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] word,
    input  logic              wide,
    input  logic              cpha,
    input  logic              lead_tick,
    input  logic              trail_tick,
    input  logic              last_edge,
    input  logic              final_sample,
    input  logic              sin,
    output logic              sout,
    output logic              rx_strobe,
    output logic [DATA_W-1:0] rx_word
);

    localparam int NW = DATA_W / 2;

    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;
    logic              sample;

    assign sample = cpha ? trail_tick : lead_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh <= '0;
            sout  <= 1'b0;
        end else if (load) begin
            tx_sh <= wide ? word : {word[NW-1:0], {NW{1'b0}}};
            if (!cpha) begin
                sout <= wide ? word[DATA_W-1] : word[NW-1];
            end
        end else if (!cpha && trail_tick && !last_edge) begin
            sout  <= tx_sh[DATA_W-2];
            tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
        end else if (cpha && lead_tick) begin
            sout  <= tx_sh[DATA_W-1];
            tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh     <= '0;
            rx_strobe <= 1'b0;
            rx_word   <= '0;
        end else begin
            rx_strobe <= sample && final_sample;
            if (sample) begin
                rx_sh <= {rx_sh[DATA_W-2:0], sin};
                if (final_sample) begin
                    rx_word <= wide ? {rx_sh[DATA_W-2:0], sin}
                                    : {{NW{1'b0}}, rx_sh[NW-2:0], sin};
                end
            end
        end
    end

endmodule

// File: rtl/spi_gap_master.sv
module spi_gap_master
    import spi_gap_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int GAP_W    = 10,
    parameter int DATA_W   = 16,
    parameter int PRE_LOG2 = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_wide,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [GAP_W-1:0]  cfg_gap,
    input  logic              cfg_gap_x32,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              busy,
    output logic              spi_clk,
    output logic              spi_out,
    input  logic              spi_in
);

    localparam int EDGE_W = $clog2(2 * DATA_W);
    localparam logic [EDGE_W-1:0] LAST_WIDE   = EDGE_W'(2 * DATA_W - 1);
    localparam logic [EDGE_W-1:0] LAST_NARROW = EDGE_W'(DATA_W - 1);

    spi_state_e        state;
    spi_state_e        state_nx;
    logic [EDGE_W-1:0] edge_cnt;
    logic [EDGE_W-1:0] last_idx;
    logic              tick;
    logic              shifting;
    logic              gap_phase;
    logic              lead_tick;
    logic              trail_tick;
    logic              at_last;
    logic              char_end;
    logic              final_sample;
    logic              gap_zero;
    logic              gap_expire;
    logic              gap_done;
    logic              accept;

    assign shifting     = (state == ST_SHIFT);
    assign gap_phase    = (state == ST_GAP);
    assign last_idx     = cfg_wide ? LAST_WIDE : LAST_NARROW;
    assign at_last      = (edge_cnt == last_idx);
    assign lead_tick    = shifting && tick && !edge_cnt[0];
    assign trail_tick   = shifting && tick && edge_cnt[0];
    assign char_end     = trail_tick && at_last;
    assign final_sample = cfg_cpha ? at_last : (edge_cnt == last_idx - EDGE_W'(1));
    assign gap_done     = gap_phase && gap_expire;
    assign tx_ready     = (state == ST_IDLE) || (char_end && gap_zero) || gap_done;
    assign accept       = tx_valid && tx_ready;

    spi_gap_baud #(.DIV_W(DIV_W)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state != ST_IDLE),
        .div   (cfg_div),
        .tick  (tick)
    );

    spi_gap_timer #(.GAP_W(GAP_W), .PRE_LOG2(PRE_LOG2)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (char_end && !gap_zero),
        .gap    (cfg_gap),
        .x32    (cfg_gap_x32),
        .tick   (tick),
        .expire (gap_expire),
        .zero   (gap_zero)
    );

    spi_gap_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (accept),
        .word         (tx_data),
        .wide         (cfg_wide),
        .cpha         (cfg_cpha),
        .lead_tick    (lead_tick),
        .trail_tick   (trail_tick),
        .last_edge    (at_last),
        .final_sample (final_sample),
        .sin          (spi_in),
        .sout         (spi_out),
        .rx_strobe    (rx_valid),
        .rx_word      (rx_data)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) state_nx = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (char_end) begin
                    if (!gap_zero)     state_nx = ST_GAP;
                    else if (tx_valid) state_nx = ST_SHIFT;
                    else               state_nx = ST_IDLE;
                end
            end
            ST_GAP: begin
                if (gap_done) state_nx = tx_valid ? ST_SHIFT : ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Registered outputs and edge position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_cnt <= '0;
            spi_clk  <= 1'b0;
            busy     <= 1'b0;
        end else begin
            busy <= (state_nx != ST_IDLE);
            if (accept) begin
                edge_cnt <= '0;
            end else if (shifting && tick) begin
                edge_cnt <= edge_cnt + EDGE_W'(1);
            end
            if (shifting && tick) begin
                spi_clk <= ~spi_clk;
            end else if (state == ST_IDLE) begin
                spi_clk <= cfg_cpol;
            end
        end
    end

endmodule

// File: rtl/spi_gap_master_chk.sv
module spi_gap_master_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_cpol,
    input logic busy,
    input logic spi_clk,
    input logic rx_valid,
    input logic tx_valid,
    input logic tx_ready,
    input logic in_gap
);

    // R1: clock rests at the polarity level while idle
    assert_idle_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && $stable(cfg_cpol)) |-> (spi_clk == cfg_cpol));

    // R1: clock rests at the polarity level during every pause
    assert_gap_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_gap |-> (spi_clk == cfg_cpol));

    // R9: receive strobe lasts one cycle
    assert_rx_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R10: an accepted word starts activity
    assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> busy);

    // R11: busy drops only with the clock back at idle
    assert_busy_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (spi_clk == cfg_cpol));

endmodule

bind spi_gap_master spi_gap_master_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_cpol (cfg_cpol),
    .busy     (busy),
    .spi_clk  (spi_clk),
    .rx_valid (rx_valid),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .in_gap   (gap_phase)
);

// File: tb/spi_gap_master_test.sv
module spi_gap_master_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    // {cpol, cpha, wide, unused, data}
    localparam logic [19:0] VEC [0:7] = '{
        20'h0_00A5, 20'h2_C3E1, 20'h4_005A, 20'h6_8001,
        20'h8_00F0, 20'hA_1234, 20'hC_0081, 20'hE_FFFE
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_cpol = 1'b0;
    logic        cfg_cpha = 1'b0;
    logic        cfg_wide = 1'b0;
    logic [7:0]  cfg_div = 8'd1;
    logic [9:0]  cfg_gap = 10'd0;
    logic        cfg_gap_x32 = 1'b0;
    logic        tx_valid = 1'b0;
    logic [15:0] tx_data = 16'h0;
    logic        tx_ready;
    logic        rx_valid;
    logic [15:0] rx_data;
    logic        busy;
    logic        spi_clk;
    logic        spi_out;
    wire         spi_in;

    int checks = 0;
    int errors = 0;

    assign spi_in = ~spi_out;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_gap_master uut (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_wide(cfg_wide), .cfg_div(cfg_div), .cfg_gap(cfg_gap),
        .cfg_gap_x32(cfg_gap_x32), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
        .busy(busy), .spi_clk(spi_clk), .spi_out(spi_out), .spi_in(spi_in)
    );

    // Serial-side monitor
    logic        mon_clr = 1'b0;
    logic        prev_clk = 1'b0;
    logic        prev_busy = 1'b0;
    int          cyc = 0;
    int          ecount = 0;
    int          edge_t [0:127];
    logic [15:0] mword = 16'h0;
    int          rx_n = 0;
    logic [15:0] rx_log [0:3];
    int          bfall = 0;

    always @(negedge clk) begin
        if (mon_clr) begin
            ecount <= 0;
            mword  <= 16'h0;
            rx_n   <= 0;
            bfall  <= 0;
        end else if (rst_n) begin
            if (spi_clk !== prev_clk) begin
                if (ecount < 128) edge_t[ecount] <= cyc;
                ecount <= ecount + 1;
                if ((prev_clk == cfg_cpol) ^ cfg_cpha) mword <= {mword[14:0], spi_out};
            end
            if (rx_valid) begin
                if (rx_n < 4) rx_log[rx_n] <= rx_data;
                rx_n <= rx_n + 1;
            end
            if (prev_busy && !busy) bfall <= cyc;
        end
        prev_clk  <= spi_clk;
        prev_busy <= busy;
        cyc       <= cyc + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(posedge clk);
        mon_clr = 1'b1;
        @(posedge clk);
        mon_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic send(input logic [15:0] w);
        tx_data  = w;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [15:0] exp_rx(input logic wide, input logic [15:0] d);
        return wide ? ~d : {8'h00, ~d[7:0]};
    endfunction

    task automatic spacing_bad(input int first, input int last, input int d, output int bad);
        bad = 0;
        for (int i = first; i <= last; i++) begin
            if (edge_t[i] - edge_t[i-1] != d) bad++;
        end
    endtask

    task automatic run_all();
        int bad;
        logic [15:0] d;
        logic [15:0] m;
        int nb;

        // Reset state: R1, R10, R11
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 busy after reset", busy, 1'b0);
        chk("R1 idle clock after reset", spi_clk, 1'b0);
        chk("R9 rx_valid after reset", rx_valid, 1'b0);
        chk("R10 tx_ready in idle", tx_ready, 1'b1);

        // Table walk: polarity, phase and size combinations, D = 2
        for (int v = 0; v < 8; v++) begin
            cfg_cpol = VEC[v][19];
            cfg_cpha = VEC[v][18];
            cfg_wide = VEC[v][17];
            d        = VEC[v][15:0];
            cfg_div  = 8'd1;
            cfg_gap  = 10'd0;
            nb       = cfg_wide ? 16 : 8;
            m        = cfg_wide ? d : {8'h00, d[7:0]};
            repeat (2) @(negedge clk);
            clear_mon();
            chk("R1 idle level", spi_clk, cfg_cpol);
            send(d);
            tx_valid = 1'b0;
            chk("R10 tx_ready low mid-character", tx_ready, 1'b0);
            chk("R11 busy during character", busy, 1'b1);
            wait_idle();
            chk("R2 edge count", ecount, 2 * nb);
            chk(cfg_cpha ? "R4 trailing-edge data" : "R3 leading-edge data", mword, m);
            chk("R9 received word", rx_log[0], exp_rx(cfg_wide, d));
            chk("R9 one strobe", rx_n, 1);
            spacing_bad(1, 2 * nb - 1, 2, bad);
            chk("R5 edge spacing", bad, 0);
            chk("R1 clock back at idle", spi_clk, cfg_cpol);
        end

        // R6: plain gap, G=3, D=2 -> 2*(1+6) = 14
        cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_wide = 1'b0;
        cfg_div = 8'd1; cfg_gap = 10'd3; cfg_gap_x32 = 1'b0;
        clear_mon();
        send(16'h003C);
        send(16'h00C3);
        tx_valid = 1'b0;
        wait_idle();
        chk("R6 gap interval plain", edge_t[16] - edge_t[15], 14);
        chk("R6 both words received", rx_n, 2);
        chk("R6 second word", rx_log[1], 16'h003C);

        // R6: scaled gap, G=2, D=1 -> 1+128 = 129
        cfg_cpol = 1'b1; cfg_cpha = 1'b1;
        cfg_div = 8'd0; cfg_gap = 10'd2; cfg_gap_x32 = 1'b1;
        repeat (2) @(negedge clk);
        clear_mon();
        send(16'h0055);
        send(16'h00AA);
        tx_valid = 1'b0;
        wait_idle();
        chk("R6 gap interval scaled", edge_t[16] - edge_t[15], 129);
        chk("R1 pause-free edge count", ecount, 32);

        // R7: seamless, three 16-bit words, D=3
        cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_wide = 1'b1;
        cfg_div = 8'd2; cfg_gap = 10'd0; cfg_gap_x32 = 1'b0;
        repeat (2) @(negedge clk);
        clear_mon();
        send(16'hA5C3);
        send(16'h0FF0);
        send(16'h8421);
        tx_valid = 1'b0;
        wait_idle();
        chk("R7 seamless edge count", ecount, 96);
        spacing_bad(1, 95, 3, bad);
        chk("R7 seamless spacing", bad, 0);
        chk("R7 seamless words", rx_n, 3);
        chk("R7 first seamless word", rx_log[0], 16'h5A3C);
        chk("R7 third seamless word", rx_log[2], 16'h7BDE);

        // R8: no word waiting, zero pause
        cfg_wide = 1'b0; cfg_div = 8'd1; cfg_gap = 10'd0;
        clear_mon();
        send(16'h0099);
        tx_valid = 1'b0;
        wait_idle();
        chk("R8 busy falls with final edge", bfall - edge_t[15], 0);
        chk("R8 no partial character", ecount, 16);

        // R8: no word waiting, G=4, D=2 -> 16
        cfg_gap = 10'd4;
        clear_mon();
        send(16'h0066);
        tx_valid = 1'b0;
        wait_idle();
        chk("R8 busy falls after pause", bfall - edge_t[15], 16);
        chk("R8 pause edge count", ecount, 16);
        chk("R11 idle after pause", busy, 1'b0);
    endtask

    initial begin
        logic timed_out;
        timed_out = 1'b0;
        fork
            run_all();
            begin
                repeat (WATCHDOG) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual expired expected completion");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule